// File: doc/BRIEF.md
# Decade Counter with Seven-Segment Decoder

This block is a synchronous modulo-ten counter whose state is decoded straight onto the seven segment lines of a common-cathode display. The count steps on each rising clock edge from zero up to nine and then returns to zero. A clock-inhibit input freezes the count. An asynchronous reset forces it back to zero. A display-enable input blanks the segments without disturbing the count.

Two auxiliary outputs support multi-digit displays and external logic. The first is a square wave at one tenth of the clock rate. Its low-to-high edge marks the wrap from nine to zero, so it can clock the next digit. The second is an active-low flag that marks the count two. A registered copy of the display-enable input, one cycle late, is passed on so that enables can be chained from digit to digit.

Top module: `decade_seg_counter`

## Requirements
- R1: While reset and inhibit are low, each rising clock edge moves the count 0,1,...,9 and then back to 0.
- R2: The segment bus is ordered {g,f,e,d,c,b,a}, active high. Counts 0..9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F (the tail of 6 and the tail of 9 are lit).
- R3: A high reset clears the count to 0 and the enable output to 0 at once, with no clock edge needed. It wins over inhibit.
- R4: While inhibit is high, clock edges leave the count unchanged.
- R5: While display enable is low, all segment lines are low in the same cycle. The count keeps advancing during this time and shows its advanced value once enable returns high.
- R6: The enable output equals the display-enable input as sampled at the previous rising clock edge.
- R7: The divide-by-ten output is high for counts 0..4 and low for counts 5..9. It rises only on the edge that wraps 9 to 0.
- R8: The not-two output is low only when the count is 2.
- R9: The divide-by-ten and not-two outputs are not affected by display enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| inhibit | input | 1 | High freezes the count |
| dispEn | input | 1 | High lights the segments, low blanks them |
| segOut | output | 7 | Segment lines {g,f,e,d,c,b,a}, active high |
| enOut | output | 1 | Display enable delayed by one clock |
| divTen | output | 1 | High for counts 0..4, low for 5..9 |
| notTwo | output | 1 | Low when the count is 2 |

## Verification
The count register is the only state between a clock edge and the segment, divide-by-ten and not-two outputs. Their values are therefore due one edge after the stimulus, and the bench samples them on the falling edge that follows. Blanking and reset act without any edge. They are checked one nanosecond after the input changes, before the next rising edge can interfere. The enable output lags by one register, so the bench checks that it still holds its old value just after a change and holds the new value after the next edge.

// File: rtl/decade_pkg.sv
package decade_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // count may move this edge
    logic wrap;     // next value is zero
  } ctrlStrobes_t;
endpackage

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
  import decade_pkg::*;
#(
  parameter int COUNT_W = 4,
  parameter int MODULUS = 10
) (
  input  logic               inhibit,
  input  logic [COUNT_W-1:0] count,
  output ctrlStrobes_t       strobes
);
  localparam logic [COUNT_W-1:0] LAST = COUNT_W'(MODULUS - 1);

  always_comb begin
    strobes.advance = !inhibit;
    // values at or above the last legal one (including illegal ones) return to zero
    strobes.wrap    = !inhibit && (count >= LAST);
  end
endmodule

// File: rtl/dcnt_datapath.sv
module dcnt_datapath
  import decade_pkg::*;
#(
  parameter int COUNT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic               dispEn,
  output logic [COUNT_W-1:0] count,
  output logic               enDly
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      count <= '0;
    end else if (strobes.wrap) begin
      count <= '0;
    end else if (strobes.advance) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) enDly <= 1'b0;
    else     enDly <= dispEn;
  end

  // R1: a wrap strobe leaves the count at zero
  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    strobes.wrap |=> count == '0);

  // R6: the enable output is the previous enable input
  a_r6_en_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> enDly == $past(dispEn));
endmodule

// File: rtl/dcnt_decode.sv
module dcnt_decode #(
  parameter int COUNT_W = 4,
  parameter int MODULUS = 10,
  parameter int SEG_W   = 7
) (
  input  logic [COUNT_W-1:0] count,
  input  logic               dispEn,
  output logic [SEG_W-1:0]   segOut,
  output logic               divTen,
  output logic               notTwo
);
  localparam logic [COUNT_W-1:0] HALF = COUNT_W'(MODULUS / 2);
  localparam logic [COUNT_W-1:0] TWO  = COUNT_W'(2);

  logic [SEG_W-1:0] glyph;

  always_comb begin
    unique case (count)
      COUNT_W'(0): glyph = SEG_W'(7'h3F);
      COUNT_W'(1): glyph = SEG_W'(7'h06);
      COUNT_W'(2): glyph = SEG_W'(7'h5B);
      COUNT_W'(3): glyph = SEG_W'(7'h4F);
      COUNT_W'(4): glyph = SEG_W'(7'h66);
      COUNT_W'(5): glyph = SEG_W'(7'h6D);
      COUNT_W'(6): glyph = SEG_W'(7'h7D);
      COUNT_W'(7): glyph = SEG_W'(7'h07);
      COUNT_W'(8): glyph = SEG_W'(7'h7F);
      COUNT_W'(9): glyph = SEG_W'(7'h6F);
      default:     glyph = '0;  // illegal values stay dark
    endcase
  end

  assign segOut = dispEn ? glyph : '0;
  assign divTen = count < HALF;
  assign notTwo = count != TWO;
endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
  import decade_pkg::*;
#(
  parameter int COUNT_W = 4,
  parameter int MODULUS = 10,
  parameter int SEG_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inhibit,
  input  logic             dispEn,
  output logic [SEG_W-1:0] segOut,
  output logic             enOut,
  output logic             divTen,
  output logic             notTwo
);
  localparam logic [COUNT_W-1:0] LAST = COUNT_W'(MODULUS - 1);

  ctrlStrobes_t       strobes;
  logic [COUNT_W-1:0] count;

  dcnt_ctrl #(.COUNT_W(COUNT_W), .MODULUS(MODULUS)) u_ctrl (
    .inhibit(inhibit), .count(count), .strobes(strobes)
  );

  dcnt_datapath #(.COUNT_W(COUNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .dispEn(dispEn),
    .count(count), .enDly(enOut)
  );

  dcnt_decode #(.COUNT_W(COUNT_W), .MODULUS(MODULUS), .SEG_W(SEG_W)) u_dec (
    .count(count), .dispEn(dispEn), .segOut(segOut),
    .divTen(divTen), .notTwo(notTwo)
  );

  // R1: free-running step
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (!inhibit && count < LAST) |=> count == $past(count) + 1'b1);

  // R4: inhibit freezes the count
  a_r4_inhibit_hold: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> $stable(count));

  // R3: a held reset keeps count and enable output at zero
  a_r3_reset_clear: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (count == '0 && !enOut));

  // R7: divide-by-ten rises only on the wrap to zero
  a_r7_div_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(divTen) |-> (count == '0 && $past(count) == LAST));

  // R8: not-two low means the glyph for two when lit
  a_r8_not_two: assert property (@(posedge clk) disable iff (rst)
    (!notTwo && dispEn) |-> segOut == SEG_W'(7'h5B));

  // R5: blanking darkens every segment
  a_r5_blank: assert property (@(posedge clk) disable iff (rst)
    !dispEn |-> segOut == '0);
endmodule

// File: tb/decade_seg_counter_bench.sv
module decade_seg_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inhibit = 1'b0;
  logic       dispEn = 1'b1;
  logic [6:0] segOut;
  logic       enOut, divTen, notTwo;

  int nChecks = 0;
  int nFails  = 0;
  int expCount = 0;

  always #5 clk = ~clk;

  decade_seg_counter u_decade_seg_counter (
    .clk(clk), .rst(rst), .inhibit(inhibit), .dispEn(dispEn),
    .segOut(segOut), .enOut(enOut), .divTen(divTen), .notTwo(notTwo)
  );

  function automatic logic [6:0] glyphOf(input int v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!inhibit && !rst) expCount = (expCount + 1) % 10;
  endtask

  task automatic checkAll(input string req);
    check({req, " seg"}, segOut, dispEn ? glyphOf(expCount) : 7'h00);
    check({req, " R7 divTen"}, divTen, expCount < 5);
    check({req, " R8 notTwo"}, notTwo, expCount != 2);
  endtask

  task automatic testReset();
    rst = 1'b1; dispEn = 1'b1; inhibit = 1'b0;
    repeat (2) @(negedge clk);
    expCount = 0;
    check("R3 reset seg", segOut, 7'h3F);
    check("R3 reset enOut", enOut, 0);
    rst = 1'b0;
  endtask

  task automatic testSequence();
    for (int i = 0; i < 23; i++) begin
      tick();
      checkAll("R1 R2 sequence");
    end
  endtask

  task automatic testDivEdge();
    int prev;
    prev = divTen;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (!prev && divTen) check("R7 rise at wrap", expCount, 0);
      prev = divTen;
    end
  endtask

  task automatic testInhibit();
    int held;
    held = expCount;
    inhibit = 1'b1;
    repeat (4) tick();
    check("R4 hold seg", segOut, glyphOf(held));
    check("R4 hold count", expCount, held);
    inhibit = 1'b0;
    tick();
    checkAll("R4 resume");
  endtask

  task automatic testBlank();
    dispEn = 1'b0;
    #1;
    check("R5 blank now", segOut, 0);
    check("R6 enOut still old", enOut, 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5 blank", segOut, 0);
      check("R9 divTen unblanked", divTen, expCount < 5);
      check("R9 notTwo unblanked", notTwo, expCount != 2);
    end
    check("R6 enOut low", enOut, 0);
    dispEn = 1'b1;
    #1;
    check("R5 count advanced while blank", segOut, glyphOf(expCount));
    check("R6 enOut lags", enOut, 0);
    tick();
    check("R6 enOut high", enOut, 1);
    checkAll("R5 relit");
  endtask

  task automatic testAsyncReset();
    while (expCount == 0) tick();
    #2 rst = 1'b1;
    #1;
    expCount = 0;
    check("R3 async seg", segOut, 7'h3F);
    check("R3 async enOut", enOut, 0);
    check("R3 async divTen", divTen, 1);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) tick();
    inhibit = 1'b1;
    #1 rst = 1'b1;
    #1;
    expCount = 0;
    check("R3 reset beats inhibit", segOut, 7'h3F);
    @(negedge clk);
    rst = 1'b0;
    inhibit = 1'b0;
    tick();
    checkAll("R3 after release");
  endtask

  initial begin
    #1_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testSequence();
    testDivEdge();
    testInhibit();
    testBlank();
    testAsyncReset();
    testSequence();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule